// File: doc/BRIEF.md
# Time-Base Interval Timer Interrupt

This block is a free-running binary up-counter that advances by one on every pulse of an internal count-clock enable. Software picks, through a two-bit interval field, which of four counter bits marks the end of an interval. Each time that bit carries out of its position, a sticky overflow flag is set. The flag is set whether or not interrupts are enabled. When the flag and an interrupt-enable bit are both 1, the block holds a level-sensitive interrupt request toward the CPU's interrupt controller.

A single 8-bit control register gives all software access. Writes use a one-cycle strobe, and the read value is always present on the read port. Software clears the flag by writing 0 to it; writing 1 to the flag has no effect. Writing 1 to a counter-restart bit sets the whole counter to zero in one cycle. That bit always reads back as 1. Because the flag is sticky, turning the enable on while an overflow is pending raises the request on the following cycle.

The counter width and the four tap positions are parameters. The defaults are a 20-bit counter with taps at bits 12, 14, 16 and 19.

Top module: `tbt_interval_timer`

## Requirements
- R1: On each clock with `cnt_tick` high and no counter restart, the counter advances by exactly one, wrapping modulo 2^CNT_W. On a clock with `cnt_tick` low it holds its value.
- R2: The interval field is `reg_rdata[1:0]`, and values 0, 1, 2 and 3 select taps TAP0, TAP1, TAP2 and TAP3. The flag (`reg_rdata[3]`) becomes 1 one clock after the tick on which bits [tap:0] of the counter were all ones, so starting from zero the flag is set every 2^(tap+1) ticks.
- R3: The flag is set on a selected-bit carry even while the enable bit is 0.
- R4: `irq_req` is 1 exactly when the flag and the enable bit (`reg_rdata[2]`) are both 1.
- R5: A write with `reg_wdata[3]`=0 clears the flag. A write with `reg_wdata[3]`=1 leaves the flag unchanged.
- R6: If the flag is 1 when a write changes the enable bit from 0 to 1, `irq_req` is 1 in the cycle right after that write, with no further carry needed.
- R7: When a carry sets the flag in the same cycle that a write clears it, the flag ends up 1.
- R8: A write with `reg_wdata[4]`=1 makes the counter zero on the next cycle and overrides any tick in that cycle. Such a restart never sets the flag, and `reg_rdata[4]` always reads 1.
- R9: After a synchronous active-low reset, the counter is 0, the flag and enable are 0, the interval field is 0, `reg_rdata` is 8'h10, and `irq_req` is 0.
- R10: A write loads `reg_wdata[1:0]` into the interval field and `reg_wdata[2]` into the enable bit. `reg_rdata[7:5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable, one pulse per count |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| irq_req | output | 1 | Level interrupt request |

## Verification
The assertions assume that `cnt_tick`, `reg_wr` and `reg_wdata` are synchronous to `clk` and stable at the edge. They also assume that a write always presents every field, so a write meant to leave the flag alone must carry a 1 in bit 3. The stimulus therefore builds every write value from all of its fields and changes inputs only on the falling edge. The tick is gated in irregular patterns so that the hold case of the counter is exercised as well as its advance.

// File: rtl/tbt_pkg.sv
// Shared field positions and types for the time-base interval timer.
// Assumes a single 8-bit control register with fixed bit positions.
package tbt_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 2;
    localparam int NUM_TAPS = 4;
    localparam int F_SEL_LO = 0;
    localparam int F_EN     = 2;
    localparam int F_FLAG   = 3;
    localparam int F_CLR    = 4;
    typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/tbt_counter.sv
// Free-running up-counter. It advances on each tick and is zeroed by a
// restart pulse, which takes priority over the tick.
// Assumes tick and restart are synchronous single-cycle qualifiers.
module tbt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    // Counter register: restart beats tick, otherwise count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (cnt == $past(cnt) + 1'b1));
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));
    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/tbt_tap_detect.sv
// Detects a carry out of the selected counter bit. The carry occurs when
// the tick lands while bits [tap:0] are all ones. The result is a
// single-cycle set pulse, suppressed while the counter is being restarted.
// Assumes each TAPn is below CNT_W.
module tbt_tap_detect
    import tbt_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAP0  = 12,
    parameter int TAP1  = 14,
    parameter int TAP2  = 16,
    parameter int TAP3  = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic             restart,
    output logic             set_pulse
);
    logic [CNT_W-1:0] tap_mask [NUM_TAPS];
    logic [CNT_W-1:0] mask_sel;

    // Build one low-bit mask per tap position.
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_mask
        localparam int TP = (i == 0) ? TAP0 : (i == 1) ? TAP1 :
                            (i == 2) ? TAP2 : TAP3;
        assign tap_mask[i] = CNT_W'((64'd1 << (TP + 1)) - 64'd1);
    end

    // Pick the mask chosen by the interval field and test for a carry.
    always_comb begin
        mask_sel  = tap_mask[sel];
        set_pulse = tick && !restart && ((cnt & mask_sel) == mask_sel);
    end

    // R2
    carry_clears_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> ((cnt & $past(mask_sel)) == '0));
endmodule

// File: rtl/tbt_ctrl_regs.sv
// Control register holding the interval select, the enable and the sticky
// flag. It also decodes the counter restart strobe and forms the read word.
// Assumes every write presents all fields.
module tbt_ctrl_regs
    import tbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_pulse,
    output sel_t             sel,
    output logic             en,
    output logic             flag,
    output logic             restart,
    output logic [REG_W-1:0] rdata
);
    logic clr_req;
    logic [REG_W-1:0] unused_wdata;

    assign unused_wdata = wdata;
    assign clr_req      = wr && !wdata[F_FLAG];
    assign restart      = wr && wdata[F_CLR];

    // Interval select and enable load on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            en  <= 1'b0;
        end else if (wr) begin
            sel <= wdata[F_SEL_LO +: SEL_W];
            en  <= wdata[F_EN];
        end
    end

    // Sticky flag: a hardware set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (set_pulse) flag <= 1'b1;
        else if (clr_req)   flag <= 1'b0;
    end

    // Read word: restart bit reads 1, upper bits 0.
    always_comb begin
        rdata                      = '0;
        rdata[F_SEL_LO +: SEL_W]   = sel;
        rdata[F_EN]                = en;
        rdata[F_FLAG]              = flag;
        rdata[F_CLR]               = 1'b1;
    end

    // R2 R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> flag);
    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_pulse) |=> !flag);
    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[F_FLAG] && !set_pulse) |=> (flag == $past(flag)));
    // R10
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (sel == $past(wdata[F_SEL_LO +: SEL_W]) && en == $past(wdata[F_EN])));
endmodule

// File: rtl/tbt_interval_timer.sv
// Top of the time-base interval timer: counter, tap carry detector and
// control register, with a level interrupt from flag and enable.
// Assumes all inputs are synchronous to clk.
module tbt_interval_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAP0  = 12,
    parameter int TAP1  = 14,
    parameter int TAP2  = 16,
    parameter int TAP3  = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_tick,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_req
);
    logic [CNT_W-1:0] cnt;
    sel_t             sel;
    logic             en;
    logic             flag;
    logic             restart;
    logic             set_pulse;

    tbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
        .restart(restart), .cnt(cnt)
    );

    tbt_tap_detect #(
        .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_tap (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cnt(cnt),
        .tick(cnt_tick), .restart(restart), .set_pulse(set_pulse)
    );

    tbt_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .set_pulse(set_pulse), .sel(sel), .en(en), .flag(flag),
        .restart(restart), .rdata(reg_rdata)
    );

    // Level request while a pending flag is enabled.
    assign irq_req = flag && en;

    // R6
    enable_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[F_EN] && !en && flag) |=> irq_req);
    // R8
    restart_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[F_CLR] && reg_wdata[F_FLAG] && !flag) |=> !reg_rdata[F_FLAG]);
endmodule

// File: tb/tbt_interval_timer_tb.sv
module tbt_interval_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int         m_cnt  = 0;
    logic       m_flag = 0;
    logic       m_en   = 0;
    logic [1:0] m_sel  = 0;

    tbt_interval_timer #(.CNT_W(CW), .TAP0(0), .TAP1(2), .TAP2(4), .TAP3(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tap_of(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd1: return 2;
            2'd2: return 4;
            default: return 7;
        endcase
    endfunction

    function automatic logic [7:0] ctl(input int s, input bit en, input bit keep, input bit rs);
        return {3'b000, rs, keep, en, s[1:0]};
    endfunction

    task automatic check(input string tag);
        logic [7:0] exp_rd;
        logic       exp_irq;
        exp_rd  = {3'b000, 1'b1, m_flag, m_en, m_sel};
        exp_irq = m_flag & m_en;
        checks++;
        if (reg_rdata !== exp_rd || irq_req !== exp_irq) begin
            fails++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, reg_rdata, irq_req, exp_rd, exp_irq);
        end
    endtask

    // One clock: drive at negedge, update the model, sample after the edge.
    task automatic step(input bit t, input bit w, input logic [7:0] d, input string tag);
        int  mask;
        bit  rs, setp;
        @(negedge clk);
        cnt_tick = t; reg_wr = w; reg_wdata = d;
        mask = (1 << (tap_of(m_sel) + 1)) - 1;
        rs   = w && d[4];
        setp = t && !rs && ((m_cnt & mask) == mask);
        m_cnt = rs ? 0 : (t ? ((m_cnt + 1) % (1 << CW)) : m_cnt);
        if (setp) m_flag = 1;
        else if (w && !d[3]) m_flag = 0;
        if (w) begin m_sel = d[1:0]; m_en = d[2]; end
        @(posedge clk);
        #(CLK_PERIOD/4);
        cnt_tick = 0; reg_wr = 0;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check("R9");
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R9");

        // R10: readback of every select/enable pair
        for (int s = 0; s < 4; s++)
            for (int e = 0; e < 2; e++)
                step(0, 1, ctl(s, e[0], 1, 0), "R10");

        // R1: sparse ticks on the shortest tap, each tick must count
        step(0, 1, ctl(0, 0, 0, 1), "R8");
        for (int k = 0; k < 40; k++) step((k % 3) == 1, 0, 8'h0, "R1");

        // R2 R3 R4: sweep every tap, enable alternating
        for (int s = 0; s < 4; s++) begin
            step(0, 1, ctl(s, s[0], 0, 1), "R8");
            for (int k = 0; k < (2 << tap_of(s[1:0])) * 2 + 20; k++) begin
                step((k % 5) != 3, 0, 8'h0, s[0] ? "R4" : "R3");
                if (m_flag) step(0, 1, ctl(s, s[0], 0, 0), "R2");
            end
        end

        // R5: write 1 keeps, write 0 clears
        step(0, 1, ctl(0, 0, 0, 1), "R8");
        step(1, 0, 8'h0, "R2");
        step(1, 0, 8'h0, "R3");
        step(0, 1, ctl(0, 0, 1, 0), "R5");
        step(0, 1, ctl(0, 0, 0, 0), "R5");

        // R6: enable with pending flag
        step(1, 0, 8'h0, "R2");
        step(1, 0, 8'h0, "R3");
        step(0, 1, ctl(0, 1, 1, 0), "R6");
        step(0, 1, ctl(0, 0, 0, 0), "R4");

        // R7: set and clear in the same cycle
        step(0, 1, ctl(1, 1, 0, 1), "R8");
        for (int k = 0; k < 7; k++) step(1, 0, 8'h0, "R2");
        step(1, 1, ctl(1, 1, 0, 0), "R7");

        // R8: restart while about to carry suppresses the set
        step(0, 1, ctl(2, 0, 0, 1), "R8");
        for (int k = 0; k < 31; k++) step(1, 0, 8'h0, "R2");
        step(1, 1, ctl(2, 0, 1, 1), "R8");
        for (int k = 0; k < 33; k++) step(1, 0, 8'h0, "R8");

        // R9: reset again from a busy state
        @(negedge clk);
        rst_n = 0;
        m_cnt = 0; m_flag = 0; m_en = 0; m_sel = 0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R9");
        @(negedge clk);
        rst_n = 1;
        step(1, 0, 8'h0, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule